// File: doc/BRIEF.md
# Debug Break Control Register with Stretched Trigger Output

This block is the control and status word of a hardware debug break unit. It gives bus software one 32-bit register that holds the break-placement settings, a field that sets how long the external trigger pin is held active, and two banks of sticky flags. The address and data comparators outside the block drive the flag banks. Each comparator strobe latches a flag that stays set until software clears it. A flag is cleared by writing zero to it. Writing one to a flag leaves it unchanged, so software can clear one flag without disturbing the others.

Each comparator strobe also starts a trigger pulse on an output pin. The pulse lasts 1, 2, 4 or 8 clocks, as set by the width field. A strobe that arrives while a pulse is active restarts the pulse at full length. There are two reset inputs. The power-on reset clears everything. The manual reset keeps every stored bit and only cancels a trigger pulse that is in progress.

Top module: `brk_ctl_reg`

## Requirements
- R1: While the power-on reset `por_n` is low, and right after it is released, `rd_data` reads 0 and `trig_o` is low.
- R2: Bits 31:18 and 3:0 of `rd_data` always read as zero, whatever value is written to them.
- R3: Bits 7:4 are plain read/write placement bits. A write stores `wr_data[7:4]`, and the new value is visible on `rd_data` in the cycle after the write.
- R4: Bits 17:16 are a read/write width select. The codes are 0 for 1 clock, 1 for 2 clocks, 2 for 4 clocks and 3 for 8 clocks.
- R5: A high `hit_a[i]` sets flag bit 12+i, and a high `hit_b[i]` sets flag bit 8+i. The flag is set at the next clock edge and stays set until software clears it.
- R6: A write clears each flag in bits 15:8 whose written bit is 0. Each flag whose written bit is 1 keeps its value.
- R7: If a hit and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R8: A hit on any input drives `trig_o` high from the following cycle. It stays high for exactly the number of clocks chosen by bits 17:16, then returns low.
- R9: A hit while `trig_o` is high restarts the count. `trig_o` then stays high for a full width measured from the new hit, using the width select stored at that moment.
- R10: A low `mrst_n` leaves all register bits unchanged. It also forces `trig_o` low from the next cycle, ending any pulse in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; clears all state |
| mrst_n | input | 1 | Synchronous manual reset, active low; cancels the trigger pulse only |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data |
| hit_a | input | 4 | Condition-match strobes, first channel |
| hit_b | input | 4 | Condition-match strobes, second channel |
| trig_o | output | 1 | Stretched trigger output |

## Verification
Two collisions are tested. In the first, a comparator hit and a software write that clears the same flag arrive in the same cycle. The bench drives the hit together with a write of zero to that bit and expects the flag to read as set afterwards. In the second, a new hit arrives while a trigger pulse is still running. The bench sends a second hit partway through a four-clock pulse and counts the high cycles, expecting the remainder of the first pulse plus a full fresh width.

// File: rtl/brk_pkg.sv
package brk_pkg;

   // Pulse width select codes (bits 17:16 of the register)
   typedef enum logic [1:0] {
      PW_1 = 2'd0,
      PW_2 = 2'd1,
      PW_4 = 2'd2,
      PW_8 = 2'd3
   } pw_sel_e;

   // Default field placement inside the register word
   localparam int unsigned DEF_REG_W   = 32;
   localparam int unsigned DEF_CTL_LSB = 4;
   localparam int unsigned DEF_CHB_LSB = 8;
   localparam int unsigned DEF_CHA_LSB = 12;
   localparam int unsigned DEF_SEL_LSB = 16;

   // Number of clocks the trigger stays active for a given select code
   function automatic int unsigned pulse_len(input int unsigned code);
      return 32'd1 << code;
   endfunction

endpackage

// File: rtl/brk_flag_bank.sv
module brk_flag_bank #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic         wr_en,
   input  logic [N-1:0] wr_bits,
   input  logic [N-1:0] hit,
   output logic [N-1:0] flags
);

   if (N < 1) begin : g_bad_n
      $error("brk_flag_bank: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic keep;
      assign keep = !wr_en || wr_bits[i];

      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) flags[i] <= 1'b0;
         else        flags[i] <= (flags[i] && keep) || hit[i];
      end

      // R5 R7
      hit_sets_flag_chk: assert property (@(posedge clk) disable iff (!por_n)
         hit[i] |=> flags[i]);

      // R5
      flag_rise_cause_chk: assert property (@(posedge clk) disable iff (!por_n)
         $rose(flags[i]) |-> $past(hit[i]));

      // R6
      flag_fall_cause_chk: assert property (@(posedge clk) disable iff (!por_n)
         $fell(flags[i]) |-> $past(wr_en) && !$past(wr_bits[i]));
   end

endmodule

// File: rtl/brk_ctl_store.sv
module brk_ctl_store #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_bits,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("brk_ctl_store: W must be at least 1");
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)     q <= '0;
      else if (wr_en) q <= wr_bits;
   end

   // R10
   hold_without_write_chk: assert property (@(posedge clk) disable iff (!por_n)
      !wr_en |=> $stable(q));

   // R3 R4
   write_lands_chk: assert property (@(posedge clk) disable iff (!por_n)
      wr_en |=> q == $past(wr_bits));

endmodule

// File: rtl/brk_pulse_gen.sv
module brk_pulse_gen #(
   parameter int unsigned SEL_W = 2
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             mrst_n,
   input  logic             start,
   input  logic [SEL_W-1:0] sel,
   output logic             trig
);
   import brk_pkg::*;

   localparam int unsigned MAX_LEN = pulse_len((1 << SEL_W) - 1);
   localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("brk_pulse_gen: SEL_W must be 1..4");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] load_val;

   assign load_val = CNT_W'(pulse_len(int'(sel)));

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)          cnt <= '0;
      else if (!mrst_n)    cnt <= '0;
      else if (start)      cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign trig = (cnt != '0);

   // R8 R9
   start_drives_trig_chk: assert property (@(posedge clk) disable iff (!por_n)
      start && mrst_n |=> trig);

   // R10
   mrst_quiets_trig_chk: assert property (@(posedge clk) disable iff (!por_n)
      !mrst_n |=> !trig);

   // R8
   trig_rise_cause_chk: assert property (@(posedge clk) disable iff (!por_n)
      $rose(trig) |-> $past(start));

endmodule

// File: rtl/brk_ctl_reg.sv
module brk_ctl_reg #(
   parameter int unsigned REG_W   = brk_pkg::DEF_REG_W,
   parameter int unsigned FLAG_N  = 4,
   parameter int unsigned CTL_N   = 4,
   parameter int unsigned SEL_W   = 2,
   parameter int unsigned CTL_LSB = brk_pkg::DEF_CTL_LSB,
   parameter int unsigned CHB_LSB = brk_pkg::DEF_CHB_LSB,
   parameter int unsigned CHA_LSB = brk_pkg::DEF_CHA_LSB,
   parameter int unsigned SEL_LSB = brk_pkg::DEF_SEL_LSB
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              mrst_n,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  rd_data,
   input  logic [FLAG_N-1:0] hit_a,
   input  logic [FLAG_N-1:0] hit_b,
   output logic              trig_o
);

   localparam int unsigned NCH = 2;

   if (CTL_LSB + CTL_N > CHB_LSB) begin : g_ovl_ctl
      $error("brk_ctl_reg: control field overlaps channel B flags");
   end
   if (CHB_LSB + FLAG_N > CHA_LSB) begin : g_ovl_b
      $error("brk_ctl_reg: channel B flags overlap channel A flags");
   end
   if (CHA_LSB + FLAG_N > SEL_LSB) begin : g_ovl_a
      $error("brk_ctl_reg: channel A flags overlap width select");
   end
   if (SEL_LSB + SEL_W > REG_W) begin : g_ovl_sel
      $error("brk_ctl_reg: width select exceeds register");
   end

   logic [FLAG_N-1:0] hit_v   [NCH];
   logic [FLAG_N-1:0] wbits_v [NCH];
   logic [FLAG_N-1:0] flag_v  [NCH];
   logic [CTL_N-1:0]  ctl_q;
   logic [SEL_W-1:0]  sel_q;
   logic              any_hit;

   assign hit_v[0]   = hit_a;
   assign hit_v[1]   = hit_b;
   assign wbits_v[0] = wr_data[CHA_LSB +: FLAG_N];
   assign wbits_v[1] = wr_data[CHB_LSB +: FLAG_N];

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      brk_flag_bank #(.N(FLAG_N)) u_bank (
         .clk     (clk),
         .por_n   (por_n),
         .wr_en   (wr_en),
         .wr_bits (wbits_v[c]),
         .hit     (hit_v[c]),
         .flags   (flag_v[c])
      );
   end

   brk_ctl_store #(.W(CTL_N)) u_place (
      .clk     (clk),
      .por_n   (por_n),
      .wr_en   (wr_en),
      .wr_bits (wr_data[CTL_LSB +: CTL_N]),
      .q       (ctl_q)
   );

   brk_ctl_store #(.W(SEL_W)) u_width (
      .clk     (clk),
      .por_n   (por_n),
      .wr_en   (wr_en),
      .wr_bits (wr_data[SEL_LSB +: SEL_W]),
      .q       (sel_q)
   );

   assign any_hit = |{hit_a, hit_b};

   brk_pulse_gen #(.SEL_W(SEL_W)) u_pulse (
      .clk    (clk),
      .por_n  (por_n),
      .mrst_n (mrst_n),
      .start  (any_hit),
      .sel    (sel_q),
      .trig   (trig_o)
   );

   always_comb begin
      rd_data                       = '0;
      rd_data[CTL_LSB +: CTL_N]     = ctl_q;
      rd_data[CHB_LSB +: FLAG_N]    = flag_v[1];
      rd_data[CHA_LSB +: FLAG_N]    = flag_v[0];
      rd_data[SEL_LSB +: SEL_W]     = sel_q;
   end

   // R10
   mrst_keeps_reg_chk: assert property (@(posedge clk) disable iff (!por_n)
      !mrst_n && !wr_en && !any_hit |=> $stable(rd_data));

endmodule

// File: tb/brk_ctl_reg_tb.sv
module brk_ctl_reg_tb;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        mrst_n = 1'b1;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [3:0]  hit_a = '0;
   logic [3:0]  hit_b = '0;
   logic        trig_o;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   brk_ctl_reg u_dut (
      .clk     (clk),
      .por_n   (por_n),
      .mrst_n  (mrst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_data (rd_data),
      .hit_a   (hit_a),
      .hit_b   (hit_b),
      .trig_o  (trig_o)
   );

   typedef struct packed {
      logic        wr;
      logic [31:0] wd;
      logic [3:0]  ha;
      logic [3:0]  hb;
      logic [31:0] exp_rd;
   } vec_t;

   // R2 R3 R4 R5 R6 R7 walked in sequence from the reset state
   localparam vec_t VEC [8] = '{
      '{1'b1, 32'hFFFF_FFFF, 4'h0, 4'h0, 32'h0003_00F0},
      '{1'b0, 32'h0000_0000, 4'h5, 4'h0, 32'h0003_50F0},
      '{1'b0, 32'h0000_0000, 4'h0, 4'h8, 32'h0003_58F0},
      '{1'b1, 32'h0002_B7A5, 4'h0, 4'h0, 32'h0002_10A0},
      '{1'b1, 32'h0000_0000, 4'h1, 4'h2, 32'h0000_1200},
      '{1'b1, 32'h0000_EF55, 4'h0, 4'h0, 32'h0000_0250},
      '{1'b0, 32'h0000_0000, 4'h0, 4'h0, 32'h0000_0250},
      '{1'b1, 32'h0001_0000, 4'h0, 4'h0, 32'h0001_0000}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      wr_data = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Pulse hit_a[0] once, return number of high trigger cycles observed
   task automatic pulse_len(output int n, output logic first);
      @(negedge clk);
      hit_a = 4'h1;
      @(negedge clk);
      hit_a = 4'h0;
      first = trig_o;
      n = trig_o ? 1 : 0;
      repeat (20) begin
         @(negedge clk);
         if (trig_o) n++;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int n;
      logic f;

      // R1 reset state
      idle(3);
      check("R1 rd during por", rd_data, 32'h0);
      check("R1 trig during por", {31'b0, trig_o}, 32'h0);
      por_n = 1'b1;
      idle(2);
      check("R1 rd after por", rd_data, 32'h0);

      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         wr_en   = VEC[i].wr;
         wr_data = VEC[i].wd;
         hit_a   = VEC[i].ha;
         hit_b   = VEC[i].hb;
         @(negedge clk);
         wr_en = 1'b0; wr_data = '0; hit_a = '0; hit_b = '0;
         check($sformatf("R2-vector %0d (R5 R6 R7 R3 R4)", i), rd_data, VEC[i].exp_rd);
      end
      idle(12);

      // R8 width per select code
      for (int s = 0; s < 4; s++) begin
         reg_write({14'b0, 2'(s), 16'h0000});
         idle(12);
         pulse_len(n, f);
         check($sformatf("R8 first cycle sel %0d", s), {31'b0, f}, 32'h1);
         check($sformatf("R8 width sel %0d", s), n, 32'd1 << s);
      end

      // R9 retrigger mid pulse with width 4
      reg_write(32'h0002_0000);
      idle(12);
      @(negedge clk); hit_a = 4'h2;
      @(negedge clk); hit_a = 4'h0;
      n = trig_o ? 1 : 0;
      @(negedge clk); if (trig_o) n++;
      hit_b = 4'h4;
      @(negedge clk); hit_b = 4'h0; if (trig_o) n++;
      repeat (20) begin
         @(negedge clk);
         if (trig_o) n++;
      end
      check("R9 retrigger total high", n, 32'd6);

      // R10 manual reset cancels pulse, keeps register
      reg_write(32'h0003_00F0);
      idle(12);
      @(negedge clk); hit_b = 4'h1;
      @(negedge clk); hit_b = 4'h0;
      @(negedge clk); mrst_n = 1'b0;
      @(negedge clk); mrst_n = 1'b1;
      check("R10 trig after mrst", {31'b0, trig_o}, 32'h0);
      check("R10 reg kept over mrst", rd_data, 32'h0003_01F0);

      // R1 power-on reset mid run
      @(negedge clk); hit_a = 4'hF;
      @(negedge clk); hit_a = 4'h0; por_n = 1'b0;
      @(negedge clk);
      check("R1 rd after por mid run", rd_data, 32'h0);
      check("R1 trig after por mid run", {31'b0, trig_o}, 32'h0);
      por_n = 1'b1;
      idle(2);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule